// File: doc/BRIEF.md
# UART Calibration-Byte Bit-Period Estimator

This block works out the bit period of an incoming UART stream from the line itself. This removes the need for a known ratio between the host's baud rate and the local sample clock. At the start of every frame the host sends a lead byte of value zero. On the wire that byte is a single low stretch of nine bit times: the start bit followed by eight zero data bits. The estimator counts sample-clock cycles across that stretch and divides the count by nine with a bit-serial restoring divider. It then presents the quotient as a cycles-per-bit figure. A neighbouring receiver uses that figure for the rest of the frame, and a neighbouring transmitter uses it for the next reply.

A two-bit mode input selects the behaviour:
- Code 0 (and the unused code 3) bypasses the estimator and passes a programmed divisor through.
- Code 1 enables estimation and also holds off transmission until a good calibration byte has been measured. Because of this, the link cannot run full duplex in this mode.
- Code 2 enables estimation but always permits transmission, using the most recent estimate.

The receive line is expected to arrive already synchronised to the sample clock. The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `uart_bitclk_estimator`

## Requirements
- R1: With mode code 0 or 3, `bit_period_o` equals `fixed_div_i`, and `period_valid_o` and `tx_permit_o` are both 1.
- R2: With mode code 1 or 2, a measurement starts on the clock edge where `rx_i` is sampled 0 after being sampled 1 on the previous edge, provided `frame_idle_i` is 1 and no measurement or division is in progress. The measured length L is the number of consecutive edges on which `rx_i` is sampled 0.
- R3: An accepted measurement sets `bit_period_o` to floor(L / 9), and that value holds until the next accepted measurement.
- R4: Take edge E as the first edge on which `rx_i` is sampled 1 again. The accept or reject outcome appears on `period_valid_o` at edge E + CNT_W + 1, and `period_valid_o` is 0 on the edges before that.
- R5: `period_valid_o` falls on the edge that starts a measurement and stays 0 while the low stretch is being counted.
- R6: A quotient below MIN_BIT_CYCLES (default 4) is rejected. In that case `period_valid_o` stays 0 and `bit_period_o` keeps the previous accepted value.
- R7: A low stretch longer than 2^CNT_W − 1 cycles overflows the counter and is rejected in the same way as R6.
- R8: A falling edge of `rx_i` while `frame_idle_i` is 0, or while the mode code is 0 or 3, starts nothing. The estimate and its valid flag are left unchanged.
- R9: In mode code 1, `tx_permit_o` equals `period_valid_o`. It is therefore 0 from reset until the first accepted calibration byte, and 0 again during each new measurement.
- R10: In mode code 2, `tx_permit_o` is always 1.
- R11: After reset in mode code 1, `bit_period_o`, `period_valid_o` and `tx_permit_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, synchronised to clk, idle high |
| mode_i | input | 2 | 0/3 fixed divisor, 1 estimate with transmit lock, 2 estimate without lock |
| frame_idle_i | input | 1 | High while the link is between frames, arming a new calibration |
| fixed_div_i | input | CNT_W | Programmed cycles-per-bit value used when estimation is off |
| bit_period_o | output | CNT_W | Cycles per bit in use |
| period_valid_o | output | 1 | Bit period is usable |
| tx_permit_o | output | 1 | Transmitter may start a frame |

## Verification
The mode-dependent outputs are combinational, so they are checked one time unit after a mode change. Within a measurement, the valid flag must already be 0 at the first falling clock edge after the start edge. Once `rx_i` returns high, the result is due exactly CNT_W + 1 edges after the first high sample. The scoreboard monitor counts those edges from the moment the driver releases the line. It confirms the flag is still 0 one edge early, then compares flag, period and permit at the falling edge just after the due edge. Cases that must be ignored are followed by a wait longer than a division, and then compared against the previous estimate.

// File: rtl/bitest_pkg.sv
package bitest_pkg;
  // Calibration byte 0x00 plus start bit: nine low bit times on the line
  localparam int unsigned CAL_BITS = 9;

  typedef enum logic [1:0] {
    EST_OFF    = 2'd0,
    EST_LOCKED = 2'd1,
    EST_FREE   = 2'd2,
    EST_RSVD   = 2'd3
  } est_mode_e;

  typedef enum logic [1:0] {
    MS_IDLE   = 2'd0,
    MS_COUNT  = 2'd1,
    MS_DIVIDE = 2'd2
  } meas_state_e;
endpackage

// File: rtl/bitest_low_counter.sv
module bitest_low_counter #(
  parameter int unsigned W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] count_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         ovf_q, ovf_n;

  always_comb begin
    cnt_n = cnt_q;
    ovf_n = ovf_q;
    if (clr_i) begin
      cnt_n = W'(1);
      ovf_n = 1'b0;
    end else if (inc_i) begin
      if (&cnt_q) ovf_n = 1'b1;
      else        cnt_n = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i || inc_i) begin
      cnt_q <= cnt_n;
      ovf_q <= ovf_n;
    end
  end

  assign count_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/bitest_const_div.sv
module bitest_const_div #(
  parameter int unsigned W       = 20,
  parameter int unsigned DIVISOR = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  output logic [W-1:0] quot_o,
  output logic         done_o
);
  localparam int unsigned REM_W = $clog2(DIVISOR);
  localparam int unsigned K_W   = $clog2(W + 1);
  localparam logic [REM_W:0] DIV_V = (REM_W + 1)'(DIVISOR);

  logic [W-1:0]     dvd_q, dvd_n;
  logic [REM_W-1:0] rem_q, rem_n;
  logic [K_W-1:0]   k_q, k_n;
  logic             busy_q, busy_n, done_q, done_n;
  logic [REM_W:0]   trial;
  logic             fits;

  always_comb begin
    trial  = {rem_q, dvd_q[W-1]};
    fits   = (trial >= DIV_V);
    dvd_n  = dvd_q;
    rem_n  = rem_q;
    k_n    = k_q;
    busy_n = busy_q;
    done_n = 1'b0;
    if (load_i) begin
      dvd_n  = dividend_i;
      rem_n  = '0;
      k_n    = K_W'(W);
      busy_n = 1'b1;
    end else if (busy_q) begin
      // quotient bits shift in from the right as dividend bits leave on the left
      dvd_n = {dvd_q[W-2:0], fits};
      rem_n = fits ? REM_W'(trial - DIV_V) : REM_W'(trial);
      k_n   = k_q - K_W'(1);
      if (k_q == K_W'(1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      rem_q  <= '0;
      k_q    <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_n;
      if (load_i || busy_q) begin
        dvd_q  <= dvd_n;
        rem_q  <= rem_n;
        k_q    <= k_n;
        busy_q <= busy_n;
      end
    end
  end

  assign quot_o = dvd_q;
  assign done_o = done_q;
endmodule

// File: rtl/uart_bitclk_estimator.sv
module uart_bitclk_estimator
  import bitest_pkg::*;
#(
  parameter int unsigned CNT_W          = 20,
  parameter int unsigned MIN_BIT_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic [1:0]       mode_i,
  input  logic             frame_idle_i,
  input  logic [CNT_W-1:0] fixed_div_i,
  output logic [CNT_W-1:0] bit_period_o,
  output logic             period_valid_o,
  output logic             tx_permit_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_BIT_CYCLES);

  logic [1:0]       rst_pipe_q;
  logic             rst_n_s;
  logic             rx_q;
  meas_state_e      state_q, state_n;
  logic             est_valid_q, est_valid_n;
  logic [CNT_W-1:0] est_period_q;
  logic             period_en;
  logic             cnt_clr, cnt_inc, div_load, div_done, ovf;
  logic             est_en, start_w, meas_idle, accept;
  logic [CNT_W-1:0] low_count, quot;
  est_mode_e        mode;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  bitest_low_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .count_o (low_count),
    .ovf_o   (ovf)
  );

  bitest_const_div #(.W(CNT_W), .DIVISOR(CAL_BITS)) u_div (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .load_i     (div_load),
    .dividend_i (low_count),
    .quot_o     (quot),
    .done_o     (div_done)
  );

  always_comb begin
    mode        = est_mode_e'(mode_i);
    est_en      = (mode == EST_LOCKED) || (mode == EST_FREE);
    meas_idle   = (state_q == MS_IDLE);
    start_w     = est_en && frame_idle_i && rx_q && !rx_i && meas_idle;
    accept      = !ovf && (quot >= MIN_V);
    state_n     = state_q;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    div_load    = 1'b0;
    period_en   = 1'b0;
    est_valid_n = est_valid_q;
    case (state_q)
      MS_IDLE: begin
        if (start_w) begin
          state_n     = MS_COUNT;
          cnt_clr     = 1'b1;
          est_valid_n = 1'b0;
        end
      end
      MS_COUNT: begin
        if (rx_i) begin
          state_n  = MS_DIVIDE;
          div_load = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      MS_DIVIDE: begin
        if (div_done) begin
          state_n     = MS_IDLE;
          est_valid_n = accept;
          period_en   = accept;
        end
      end
      default: state_n = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rx_q         <= 1'b1;
      state_q      <= MS_IDLE;
      est_valid_q  <= 1'b0;
      est_period_q <= '0;
    end else begin
      rx_q        <= rx_i;
      state_q     <= state_n;
      est_valid_q <= est_valid_n;
      if (period_en) est_period_q <= quot;
    end
  end

  always_comb begin
    case (mode)
      EST_LOCKED: begin
        bit_period_o   = est_period_q;
        period_valid_o = est_valid_q;
        tx_permit_o    = est_valid_q;
      end
      EST_FREE: begin
        bit_period_o   = est_period_q;
        period_valid_o = est_valid_q;
        tx_permit_o    = 1'b1;
      end
      default: begin
        bit_period_o   = fixed_div_i;
        period_valid_o = 1'b1;
        tx_permit_o    = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/bitest_chk.sv
module bitest_chk #(
  parameter int unsigned CNT_W          = 20,
  parameter int unsigned MIN_BIT_CYCLES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_i,
  input logic             rx_q,
  input logic [1:0]       mode_i,
  input logic             frame_idle_i,
  input logic             meas_idle,
  input logic             div_done,
  input logic             ovf,
  input logic             est_valid,
  input logic [CNT_W-1:0] est_period,
  input logic [CNT_W-1:0] fixed_div_i,
  input logic [CNT_W-1:0] bit_period_o,
  input logic             period_valid_o,
  input logic             tx_permit_o
);
  // R1
  a_r1_fixed_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd0 || mode_i == 2'd3) |->
      (bit_period_o == fixed_div_i && period_valid_o && tx_permit_o));

  // R10
  a_r10_free_permit: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd2) |-> tx_permit_o);

  // R9
  a_r9_locked_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'd1 && !period_valid_o) |-> !tx_permit_o);

  // R5
  a_r5_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == 2'd1 || mode_i == 2'd2) && frame_idle_i && rx_q && !rx_i && meas_idle)
      |=> !est_valid);

  // R4
  a_r4_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(est_valid) |-> $past(div_done));

  // R6
  a_r6_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    est_valid |-> (est_period >= CNT_W'(MIN_BIT_CYCLES)));

  // R7
  a_r7_ovf_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !est_valid);

  // R3
  a_r3_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (est_valid && $past(est_valid)) |-> $stable(est_period));
endmodule

bind uart_bitclk_estimator bitest_chk #(
  .CNT_W          (CNT_W),
  .MIN_BIT_CYCLES (MIN_BIT_CYCLES)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_s),
  .rx_i           (rx_i),
  .rx_q           (rx_q),
  .mode_i         (mode_i),
  .frame_idle_i   (frame_idle_i),
  .meas_idle      (meas_idle),
  .div_done       (div_done),
  .ovf            (ovf),
  .est_valid      (est_valid_q),
  .est_period     (est_period_q),
  .fixed_div_i    (fixed_div_i),
  .bit_period_o   (bit_period_o),
  .period_valid_o (period_valid_o),
  .tx_permit_o    (tx_permit_o)
);

// File: tb/uart_bitclk_estimator_test.sv
module uart_bitclk_estimator_test;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_i;
  logic [1:0]    mode_i;
  logic          frame_idle_i;
  logic [TW-1:0] fixed_div_i;
  logic [TW-1:0] bit_period_o;
  logic          period_valid_o;
  logic          tx_permit_o;

  int n_vec = 0;
  int n_bad = 0;
  int last_per = 0;
  bit mon_busy = 1'b0;
  bit done_flag = 1'b0;

  typedef struct {
    bit    acc;
    int    per;
    int    mode;
    string tag;
  } exp_t;
  exp_t sb[$];

  uart_bitclk_estimator #(.CNT_W(TW), .MIN_BIT_CYCLES(4)) uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_i           (rx_i),
    .mode_i         (mode_i),
    .frame_idle_i   (frame_idle_i),
    .fixed_div_i    (fixed_div_i),
    .bit_period_o   (bit_period_o),
    .period_valid_o (period_valid_o),
    .tx_permit_o    (tx_permit_o)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // driver: one calibration byte of L low cycles in mode m
  task automatic cal_byte(input int L, input int m);
    exp_t e;
    int   q;
    bit   ov;
    mode_i       = 2'(m);
    frame_idle_i = 1'b1;
    rx_i         = 1'b0;
    for (int i = 0; i < L; i++) begin
      @(negedge clk);
      if (i == 0) begin
        check(period_valid_o == 1'b0, "R5 valid low while counting", int'(period_valid_o), 0);
        if (m == 1) check(tx_permit_o == 1'b0, "R9 permit low while counting", int'(tx_permit_o), 0);
        else        check(tx_permit_o == 1'b1, "R10 permit high while counting", int'(tx_permit_o), 1);
      end
    end
    rx_i = 1'b1;
    ov = (L > (1 << TW) - 1);
    q  = L / 9;
    e.acc  = !ov && (q >= 4);
    e.mode = m;
    if (e.acc) begin
      last_per = q;
      e.tag = (L == 36) ? "R2 R3 minimum accepted" : "R3 quotient";
    end else begin
      e.tag = ov ? "R7 overflow rejected" : "R6 short period rejected";
    end
    e.per = last_per;
    sb.push_back(e);
    wait (sb.size() == 0 && !mon_busy);
    repeat (3) @(negedge clk);
  endtask

  // monitor: result due CNT_W+1 edges after the first high sample
  initial begin
    exp_t e;
    forever begin
      wait (sb.size() != 0);
      e = sb.pop_front();
      mon_busy = 1'b1;
      repeat (TW + 1) @(posedge clk);
      @(negedge clk);
      check(period_valid_o == 1'b0, "R4 valid not before due edge", int'(period_valid_o), 0);
      @(posedge clk);
      @(negedge clk);
      check(period_valid_o == e.acc, {e.tag, " valid"}, int'(period_valid_o), int'(e.acc));
      check(int'(bit_period_o) == e.per, {e.tag, " period"}, int'(bit_period_o), e.per);
      if (e.mode == 1)
        check(tx_permit_o == e.acc, "R9 permit follows valid", int'(tx_permit_o), int'(e.acc));
      else
        check(tx_permit_o == 1'b1, "R10 permit always high", int'(tx_permit_o), 1);
      mon_busy = 1'b0;
    end
  end

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n        = 1'b0;
    rx_i         = 1'b1;
    mode_i       = 2'd1;
    frame_idle_i = 1'b1;
    fixed_div_i  = TW'(123);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    check(bit_period_o == '0, "R11 reset period", int'(bit_period_o), 0);
    check(period_valid_o == 1'b0, "R11 reset valid", int'(period_valid_o), 0);
    check(tx_permit_o == 1'b0, "R11 reset permit", int'(tx_permit_o), 0);

    // R1 fixed divisor in codes 0 and 3
    mode_i = 2'd0; #1;
    check(int'(bit_period_o) == 123 && period_valid_o && tx_permit_o, "R1 mode 0", int'(bit_period_o), 123);
    mode_i = 2'd3; #1;
    check(int'(bit_period_o) == 123 && period_valid_o && tx_permit_o, "R1 mode 3", int'(bit_period_o), 123);

    // R8 falling edge in mode 0 starts nothing
    @(negedge clk);
    mode_i = 2'd0;
    rx_i   = 1'b0;
    repeat (50) @(negedge clk);
    rx_i = 1'b1;
    repeat (TW + 4) @(negedge clk);
    mode_i = 2'd1; #1;
    check(period_valid_o == 1'b0, "R8 mode 0 edge ignored", int'(period_valid_o), 0);
    @(negedge clk);

    cal_byte(36, 1);
    cal_byte(90, 1);
    cal_byte(521, 1);
    cal_byte(35, 1);
    cal_byte(4095, 1);
    cal_byte(4096, 1);
    cal_byte(100, 2);

    // R8 frame_idle low: estimate of 11 must survive
    mode_i       = 2'd1;
    frame_idle_i = 1'b0;
    rx_i         = 1'b0;
    repeat (50) @(negedge clk);
    rx_i = 1'b1;
    repeat (TW + 4) @(negedge clk);
    check(period_valid_o == 1'b1, "R8 idle low valid kept", int'(period_valid_o), 1);
    check(int'(bit_period_o) == 11, "R8 idle low period kept", int'(bit_period_o), 11);
    check(tx_permit_o == 1'b1, "R9 permit with valid estimate", int'(tx_permit_o), 1);

    // R8 falling edge during mode 0 leaves estimate intact
    frame_idle_i = 1'b1;
    mode_i       = 2'd0;
    rx_i         = 1'b0;
    repeat (60) @(negedge clk);
    rx_i = 1'b1;
    repeat (TW + 4) @(negedge clk);
    mode_i = 2'd1; #1;
    check(period_valid_o == 1'b1, "R8 mode 0 valid kept", int'(period_valid_o), 1);
    check(int'(bit_period_o) == 11, "R8 mode 0 period kept", int'(bit_period_o), 11);
    @(negedge clk);

    cal_byte(72, 2);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule